// File: doc/BRIEF.md
# Flash Endurance Read-Back Error Tally

This block sits beside the read path of a flash endurance rig. Each test iteration erases a block, fills it with a pseudo-random pattern and then reads it back. While the read-back stream passes, the block regenerates the pattern locally, one word per valid read. It compares each word with what the flash returned and sorts every wrong bit by direction. A "rise" error is a bit stored as 0 that reads back as 1. A "fall" error is a bit stored as 1 that reads back as 0.

Two kinds of tally are kept. The first is a cumulative pair of counters for every page, which a query port reads. The second is a set of running counters for the current measurement window, split by direction and by page parity. A window spans a fixed number of consecutive iterations, and that number depends on the cell type: 200 for single-level cells and 50 for multi-level cells. When a window closes, its totals and the number of bits compared are latched and presented with a one-cycle strobe. The error-rate average for the window is the latched error total divided by the latched bit total.

Top module: `flash_err_tally`

## Requirements
- R1: The reference word is a right-shifting Galois LFSR state. The next state is `{1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 0)`, the reset and reseed value is `32'hACE1_2468`, and the state advances once for each cycle with `rd_valid` high. A cycle with `iter_start` high reseeds the LFSR, and a word valid in that same cycle is compared against the seed itself.
- R2: Each bit with reference 0 and read value 1 adds one rise error.
- R3: Each bit with reference 1 and read value 0 adds one fall error.
- R4: A word whose page index has bit 0 set counts into the odd-page running counters; any other word counts into the even-page counters. The counters update at the clock edge that samples the word.
- R5: Every page keeps cumulative rise and fall counts since reset. Window closes never clear them, and `qry_rise`/`qry_fall` show the counts for `qry_page` combinationally.
- R6: All counters saturate at their all-ones value instead of wrapping.
- R7: The first `iter_start` after reset opens iteration 1. Each later `iter_start` ends the current iteration. A window closes at the `iter_start` that ends its Nth iteration, where N is 200 when `mlc_mode` is 0 and 50 when it is 1. `mlc_mode` is sampled at each `iter_start`.
- R8: In the cycle after a closing edge, `win_valid` is high for exactly one cycle. At the same time `win_rise` and `win_fall` take the window's summed counts, `win_bits` takes 32 times the number of words compared in the window, and the four running counters are cleared. The `win_*` values hold until the next close.
- R9: A word valid in the cycle of a closing `iter_start` belongs to the new window. It is left out of the latched totals and is the only contribution in the running counters afterwards.
- R10: After reset every counter and every window output reads zero and `win_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mlc_mode | input | 1 | 1 selects the multi-level window length, 0 the single-level length |
| iter_start | input | 1 | Start of an iteration's read-back; reseeds the pattern |
| rd_valid | input | 1 | `rd_data` holds a read-back word |
| rd_page | input | 6 | Page index of the word |
| rd_data | input | 32 | Read-back word |
| qry_page | input | 6 | Page selected for the cumulative query |
| qry_rise | output | PG_CNT_W | Cumulative rise errors of `qry_page` |
| qry_fall | output | PG_CNT_W | Cumulative fall errors of `qry_page` |
| run_rise_odd | output | WIN_CNT_W | Window rise errors on odd pages |
| run_rise_even | output | WIN_CNT_W | Window rise errors on even pages |
| run_fall_odd | output | WIN_CNT_W | Window fall errors on odd pages |
| run_fall_even | output | WIN_CNT_W | Window fall errors on even pages |
| win_valid | output | 1 | One-cycle strobe for a closed window |
| win_rise | output | WIN_CNT_W | Latched rise total of the last window |
| win_fall | output | WIN_CNT_W | Latched fall total of the last window |
| win_bits | output | WIN_CNT_W | Latched count of bits compared in the last window |

## Verification
A window close and a word comparison can happen in the same cycle, because the closing `iter_start` may carry a valid word. The bench makes this collision happen at every window boundary by sending a word in every `iter_start` cycle. It then checks that the latched totals leave that word out, that the running counters afterwards hold only that word's errors, and that the word was compared against the seed. Two window closes are driven, one in multi-level mode and one in single-level mode. Random sparse error masks are mixed with all-bits-flipped and error-free words. A single page is hammered until its narrow cumulative counters clamp.

// File: rtl/fet_pkg.sv
// Package: shared constants and types for the read-back error tally.
// Assumes a 32-bit pattern; other widths need their own seed and taps.
package fet_pkg;
    localparam logic [31:0] DEF_SEED = 32'hACE1_2468;
    localparam logic [31:0] DEF_TAPS = 32'h8020_0003;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } page_par_e;
endpackage

// File: rtl/fet_pattern_gen.sv
// Pattern regenerator: Galois LFSR producing the reference word.
// Assumes reseed and advance may both be high; the word of that cycle is the seed.
module fet_pattern_gen #(
    parameter int          W    = 32,
    parameter logic [W-1:0] SEED = '1,
    parameter logic [W-1:0] TAPS = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reseed,
    input  logic         advance,
    output logic [W-1:0] expected
);
    logic [W-1:0] state_q;

    function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] s);
        return {1'b0, s[W-1:1]} ^ (s[0] ? TAPS : '0);
    endfunction

    // Select the reference word for the current cycle.
    always_comb expected = reseed ? SEED : state_q;

    // Step or reload the LFSR state.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= SEED;
        else if (advance) state_q <= lfsr_next(expected);
        else if (reseed)  state_q <= SEED;
    end
endmodule

// File: rtl/fet_classifier.sv
// Direction classifier: counts rise (0->1) and fall (1->0) bits of one word.
// Purely combinational; assumes NW can hold W.
module fet_classifier #(
    parameter int W  = 32,
    parameter int NW = $clog2(W + 1)
) (
    input  logic [W-1:0]  expected,
    input  logic [W-1:0]  actual,
    output logic [NW-1:0] rise_n,
    output logic [NW-1:0] fall_n
);
    // Population counts of the two mismatch directions.
    always_comb begin
        rise_n = '0;
        fall_n = '0;
        for (int i = 0; i < W; i++) begin
            rise_n += NW'(~expected[i] & actual[i]);
            fall_n += NW'(expected[i] & ~actual[i]);
        end
    end
endmodule

// File: rtl/fet_page_bank.sv
// Page bank: cumulative, saturating rise/fall counters for every page.
// Assumes CW+1 >= NW; counters are never cleared except by reset.
module fet_page_bank #(
    parameter int PAGES = 64,
    parameter int PW    = $clog2(PAGES),
    parameter int CW    = 16,
    parameter int NW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_page,
    input  logic [NW-1:0] rise_n,
    input  logic [NW-1:0] fall_n,
    input  logic [PW-1:0] qry_page,
    output logic [CW-1:0] qry_rise,
    output logic [CW-1:0] qry_fall
);
    logic [CW-1:0] rise_all [PAGES];
    logic [CW-1:0] fall_all [PAGES];

    function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [NW-1:0] b);
        logic [CW:0] s;
        s = {1'b0, a} + (CW+1)'(b);
        return s[CW] ? {CW{1'b1}} : s[CW-1:0];
    endfunction

    for (genvar p = 0; p < PAGES; p++) begin : g_page
        logic          hit;
        logic [CW-1:0] rise_q;
        logic [CW-1:0] fall_q;
        assign hit = wr_en && (wr_page == PW'(p));
        // Accumulate this page's errors with saturation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rise_q <= '0;
                fall_q <= '0;
            end else if (hit) begin
                rise_q <= sat_add(rise_q, rise_n);
                fall_q <= sat_add(fall_q, fall_n);
            end
        end
        assign rise_all[p] = rise_q;
        assign fall_all[p] = fall_q;
    end

    assign qry_rise = rise_all[qry_page];
    assign qry_fall = fall_all[qry_page];
endmodule

// File: rtl/fet_window.sv
// Window tracker: counts iterations, accumulates per-parity per-direction
// errors and compared bits, and latches totals when a window closes.
// Assumes the closing iter_start's own word belongs to the next window.
module fet_window #(
    parameter int W       = 32,
    parameter int NW      = 6,
    parameter int CW      = 24,
    parameter int WIN_SLC = 200,
    parameter int WIN_MLC = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mlc_mode,
    input  logic          iter_start,
    input  logic          word_en,
    input  logic          odd_page,
    input  logic [NW-1:0] rise_n,
    input  logic [NW-1:0] fall_n,
    output logic [CW-1:0] run_rise_odd,
    output logic [CW-1:0] run_rise_even,
    output logic [CW-1:0] run_fall_odd,
    output logic [CW-1:0] run_fall_even,
    output logic          win_valid,
    output logic [CW-1:0] win_rise,
    output logic [CW-1:0] win_fall,
    output logic [CW-1:0] win_bits
);
    localparam int WMAX = (WIN_SLC > WIN_MLC) ? WIN_SLC : WIN_MLC;
    localparam int IW   = $clog2(WMAX + 1);

    logic          started_q;
    logic [IW-1:0] iter_q;
    logic [IW-1:0] limit;
    logic          close;
    logic [CW-1:0] bits_q;
    logic [NW-1:0] inc_ro, inc_re, inc_fo, inc_fe, inc_bits;

    function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [NW-1:0] b);
        logic [CW:0] s;
        s = {1'b0, a} + (CW+1)'(b);
        return s[CW] ? {CW{1'b1}} : s[CW-1:0];
    endfunction

    function automatic logic [CW-1:0] sat_sum(input logic [CW-1:0] a, input logic [CW-1:0] b);
        logic [CW:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CW] ? {CW{1'b1}} : s[CW-1:0];
    endfunction

    // Window length and close decision for this cycle.
    always_comb begin
        limit = mlc_mode ? IW'(WIN_MLC) : IW'(WIN_SLC);
        close = iter_start && started_q && (iter_q >= limit - IW'(1));
    end

    // Route the word's counts to the parity bins.
    always_comb begin
        inc_ro   = (word_en &&  odd_page) ? rise_n : '0;
        inc_re   = (word_en && !odd_page) ? rise_n : '0;
        inc_fo   = (word_en &&  odd_page) ? fall_n : '0;
        inc_fe   = (word_en && !odd_page) ? fall_n : '0;
        inc_bits = word_en ? NW'(W) : '0;
    end

    // Iteration bookkeeping within the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            iter_q    <= '0;
        end else if (iter_start) begin
            started_q <= 1'b1;
            if (started_q) iter_q <= close ? '0 : iter_q + IW'(1);
        end
    end

    // Running accumulators, cleared on close before adding this word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_rise_odd  <= '0;
            run_rise_even <= '0;
            run_fall_odd  <= '0;
            run_fall_even <= '0;
            bits_q        <= '0;
        end else begin
            run_rise_odd  <= sat_add(close ? '0 : run_rise_odd,  inc_ro);
            run_rise_even <= sat_add(close ? '0 : run_rise_even, inc_re);
            run_fall_odd  <= sat_add(close ? '0 : run_fall_odd,  inc_fo);
            run_fall_even <= sat_add(close ? '0 : run_fall_even, inc_fe);
            bits_q        <= sat_add(close ? '0 : bits_q,        inc_bits);
        end
    end

    // Latch window totals and raise the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_rise  <= '0;
            win_fall  <= '0;
            win_bits  <= '0;
        end else begin
            win_valid <= close;
            if (close) begin
                win_rise <= sat_sum(run_rise_odd, run_rise_even);
                win_fall <= sat_sum(run_fall_odd, run_fall_even);
                win_bits <= bits_q;
            end
        end
    end
endmodule

// File: rtl/flash_err_tally.sv
// Top: regenerates the written pattern, classifies read-back mismatches by
// direction, and tallies them per page and per window.
// Assumes one read word per cycle at most and iter_start as a single-cycle pulse.
module flash_err_tally #(
    parameter int          DATA_W    = 32,
    parameter int          PAGES     = 64,
    parameter int          PG_CNT_W  = 16,
    parameter int          WIN_CNT_W = 24,
    parameter int          WIN_SLC   = 200,
    parameter int          WIN_MLC   = 50,
    parameter logic [31:0] SEED      = fet_pkg::DEF_SEED,
    parameter logic [31:0] TAPS      = fet_pkg::DEF_TAPS,
    localparam int         PW        = $clog2(PAGES),
    localparam int         NW        = $clog2(DATA_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mlc_mode,
    input  logic                 iter_start,
    input  logic                 rd_valid,
    input  logic [PW-1:0]        rd_page,
    input  logic [DATA_W-1:0]    rd_data,
    input  logic [PW-1:0]        qry_page,
    output logic [PG_CNT_W-1:0]  qry_rise,
    output logic [PG_CNT_W-1:0]  qry_fall,
    output logic [WIN_CNT_W-1:0] run_rise_odd,
    output logic [WIN_CNT_W-1:0] run_rise_even,
    output logic [WIN_CNT_W-1:0] run_fall_odd,
    output logic [WIN_CNT_W-1:0] run_fall_even,
    output logic                 win_valid,
    output logic [WIN_CNT_W-1:0] win_rise,
    output logic [WIN_CNT_W-1:0] win_fall,
    output logic [WIN_CNT_W-1:0] win_bits
);
    logic [DATA_W-1:0]  ref_word;
    logic [NW-1:0]      rise_n, fall_n;
    fet_pkg::page_par_e parity;

    assign parity = rd_page[0] ? fet_pkg::PAR_ODD : fet_pkg::PAR_EVEN;

    fet_pattern_gen #(.W(DATA_W), .SEED(SEED[DATA_W-1:0]), .TAPS(TAPS[DATA_W-1:0])) u_pat (
        .clk(clk), .rst_n(rst_n), .reseed(iter_start), .advance(rd_valid), .expected(ref_word)
    );

    fet_classifier #(.W(DATA_W), .NW(NW)) u_cls (
        .expected(ref_word), .actual(rd_data), .rise_n(rise_n), .fall_n(fall_n)
    );

    fet_page_bank #(.PAGES(PAGES), .PW(PW), .CW(PG_CNT_W), .NW(NW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(rd_valid), .wr_page(rd_page),
        .rise_n(rise_n), .fall_n(fall_n), .qry_page(qry_page),
        .qry_rise(qry_rise), .qry_fall(qry_fall)
    );

    fet_window #(.W(DATA_W), .NW(NW), .CW(WIN_CNT_W), .WIN_SLC(WIN_SLC), .WIN_MLC(WIN_MLC)) u_win (
        .clk(clk), .rst_n(rst_n), .mlc_mode(mlc_mode), .iter_start(iter_start),
        .word_en(rd_valid), .odd_page(parity == fet_pkg::PAR_ODD),
        .rise_n(rise_n), .fall_n(fall_n),
        .run_rise_odd(run_rise_odd), .run_rise_even(run_rise_even),
        .run_fall_odd(run_fall_odd), .run_fall_even(run_fall_even),
        .win_valid(win_valid), .win_rise(win_rise), .win_fall(win_fall), .win_bits(win_bits)
    );
endmodule

// File: rtl/fet_checker.sv
// Checker: temporal properties of the tally outputs, bound to the top.
module fet_checker #(
    parameter int CW  = 24,
    parameter int PCW = 16,
    parameter int PW  = 6,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           iter_start,
    input logic           rd_valid,
    input logic [PW-1:0]  qry_page,
    input logic [PCW-1:0] qry_rise,
    input logic [PCW-1:0] qry_fall,
    input logic [CW-1:0]  run_rise_odd,
    input logic [CW-1:0]  run_rise_even,
    input logic [CW-1:0]  run_fall_odd,
    input logic [CW-1:0]  run_fall_even,
    input logic           win_valid,
    input logic [CW-1:0]  win_rise,
    input logic [CW-1:0]  win_fall,
    input logic [CW-1:0]  win_bits
);
    // Sum of the running counters, widened so it cannot wrap.
    logic [CW+1:0] run_sum;
    assign run_sum = (CW+2)'(run_rise_odd) + (CW+2)'(run_rise_even)
                   + (CW+2)'(run_fall_odd) + (CW+2)'(run_fall_even);

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> !win_valid);

    assert_cleared_on_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> run_sum <= (CW+2)'(DW));

    assert_totals_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> ($stable(win_rise) && $stable(win_fall) && $stable(win_bits)));

    assert_errors_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((CW+1)'(win_rise) + (CW+1)'(win_fall) <= (CW+1)'(win_bits)));

    assert_idle_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && !iter_start) |=> ($stable(run_rise_odd) && $stable(run_rise_even)
                                        && $stable(run_fall_odd) && $stable(run_fall_even)));

    assert_page_no_decrease_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(qry_page) |-> (qry_rise >= $past(qry_rise) && qry_fall >= $past(qry_fall)));
endmodule

bind flash_err_tally fet_checker #(.CW(WIN_CNT_W), .PCW(PG_CNT_W), .PW(PW), .DW(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .iter_start(iter_start), .rd_valid(rd_valid),
    .qry_page(qry_page), .qry_rise(qry_rise), .qry_fall(qry_fall),
    .run_rise_odd(run_rise_odd), .run_rise_even(run_rise_even),
    .run_fall_odd(run_fall_odd), .run_fall_even(run_fall_even),
    .win_valid(win_valid), .win_rise(win_rise), .win_fall(win_fall), .win_bits(win_bits)
);

// File: tb/flash_err_tally_tb.sv
module flash_err_tally_tb;
    localparam int          PG_CW = 10;
    localparam int          WCW   = 24;
    localparam logic [31:0] SEED  = 32'hACE1_2468;
    localparam logic [31:0] TAPS  = 32'h8020_0003;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mlc_mode = 1'b0, iter_start = 1'b0, rd_valid = 1'b0;
    logic [5:0]  rd_page = '0, qry_page = '0;
    logic [31:0] rd_data = '0;
    logic [PG_CW-1:0] qry_rise, qry_fall;
    logic [WCW-1:0] run_rise_odd, run_rise_even, run_fall_odd, run_fall_even;
    logic win_valid;
    logic [WCW-1:0] win_rise, win_fall, win_bits;

    always #5 clk = ~clk;

    flash_err_tally #(.PG_CNT_W(PG_CW), .WIN_CNT_W(WCW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mlc_mode(mlc_mode), .iter_start(iter_start),
        .rd_valid(rd_valid), .rd_page(rd_page), .rd_data(rd_data), .qry_page(qry_page),
        .qry_rise(qry_rise), .qry_fall(qry_fall),
        .run_rise_odd(run_rise_odd), .run_rise_even(run_rise_even),
        .run_fall_odd(run_fall_odd), .run_fall_even(run_fall_even),
        .win_valid(win_valid), .win_rise(win_rise), .win_fall(win_fall), .win_bits(win_bits)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    int windows_seen = 0;

    // Reference model state.
    logic [31:0] m_lfsr = SEED;
    bit m_started = 0;
    int m_icnt = 0;
    longint m_ro = 0, m_re = 0, m_fo = 0, m_fe = 0, m_bits = 0;
    longint m_wr = 0, m_wf = 0, m_wb = 0;
    longint m_pr [64];
    longint m_pf [64];

    function automatic longint clamp(input longint v, input int w);
        longint mx = (longint'(1) << w) - 1;
        return (v > mx) ? mx : v;
    endfunction

    function automatic logic [31:0] step_lfsr(input logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? TAPS : 32'h0);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // One cycle: drive at negedge, update model, sample at next negedge.
    task automatic cyc(input bit ist, input bit vld, input logic [5:0] pg, input logic [31:0] errm);
        logic [31:0] ex, rd;
        int pn, mn, lim;
        bit cl;
        ex  = ist ? SEED : m_lfsr;
        rd  = ex ^ errm;
        pn  = $countones(~ex & rd);
        mn  = $countones(ex & ~rd);
        lim = mlc_mode ? 50 : 200;
        cl  = ist && m_started && (m_icnt >= lim - 1);
        if (cl) begin
            m_wr = clamp(m_ro + m_re, WCW);
            m_wf = clamp(m_fo + m_fe, WCW);
            m_wb = m_bits;
            m_ro = 0; m_re = 0; m_fo = 0; m_fe = 0; m_bits = 0;
        end
        if (ist) begin
            if (m_started) m_icnt = cl ? 0 : m_icnt + 1;
            m_started = 1;
        end
        if (vld) begin
            if (pg[0]) begin m_ro = clamp(m_ro + pn, WCW); m_fo = clamp(m_fo + mn, WCW); end
            else       begin m_re = clamp(m_re + pn, WCW); m_fe = clamp(m_fe + mn, WCW); end
            m_bits = clamp(m_bits + 32, WCW);
            m_pr[pg] = clamp(m_pr[pg] + pn, PG_CW);
            m_pf[pg] = clamp(m_pf[pg] + mn, PG_CW);
            m_lfsr = step_lfsr(ex);
        end else if (ist) m_lfsr = SEED;
        iter_start = ist; rd_valid = vld; rd_page = pg; rd_data = rd;
        @(posedge clk); @(negedge clk);
        iter_start = 0; rd_valid = 0;
        if (cl || win_valid) begin
            chk("R7 win_valid timing", longint'(win_valid), longint'(cl));
            if (cl) begin
                windows_seen++;
                chk("R8 win_rise", win_rise, m_wr);
                chk("R8 win_fall", win_fall, m_wf);
                chk("R8 win_bits", win_bits, m_wb);
                chk("R9 run after close", longint'(run_rise_odd) + run_rise_even + run_fall_odd + run_fall_even,
                    vld ? longint'(pn + mn) : 0);
            end
        end
    endtask

    task automatic chk_running(input string tag);
        chk({tag, " R2 R4 rise odd"},  run_rise_odd,  m_ro);
        chk({tag, " R2 R4 rise even"}, run_rise_even, m_re);
        chk({tag, " R3 R4 fall odd"},  run_fall_odd,  m_fo);
        chk({tag, " R3 R4 fall even"}, run_fall_even, m_fe);
    endtask

    function automatic logic [31:0] sparse();
        return $urandom & $urandom & $urandom;
    endfunction

    task automatic iteration(input int words, input bit directed);
        cyc(1'b1, 1'b1, 6'($urandom % 64), sparse());
        for (int k = 0; k < words; k++) begin
            logic [31:0] m;
            m = sparse();
            if (directed && k == 0) m = 32'hFFFF_FFFF;
            if (directed && k == 1) m = 32'h0;
            cyc(1'b0, 1'b1, 6'($urandom % 64), m);
        end
        cyc(1'b0, 1'b0, 6'd0, 32'h0);
        chk_running("iter");
    endtask

    initial begin
        void'($urandom(32'd20240607));
        for (int p = 0; p < 64; p++) begin m_pr[p] = 0; m_pf[p] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 run", longint'(run_rise_odd) + run_rise_even + run_fall_odd + run_fall_even, 0);
        chk("R10 win_valid", win_valid, 0);
        chk("R10 win totals", longint'(win_rise) + win_fall + win_bits, 0);
        chk("R10 qry", longint'(qry_rise) + qry_fall, 0);

        // R1: words before any iter_start follow the LFSR from the seed; flip-free word gives zero
        cyc(1'b0, 1'b1, 6'd2, 32'h0);
        cyc(1'b0, 1'b1, 6'd3, 32'h0000_0001);
        chk_running("R1 pattern");

        // R7: multi-level window of 50 iterations
        mlc_mode = 1'b1;
        for (int it = 0; it < 51; it++) iteration(2 + ($urandom % 3), it == 7);
        chk("R7 mlc window count", windows_seen, 1);

        // R7: single-level window of 200 iterations
        mlc_mode = 1'b0;
        for (int it = 0; it < 200; it++) iteration(1 + ($urandom % 2), it == 100);
        chk("R7 slc window count", windows_seen, 2);

        // R6: hammer page 5 with fully inverted words until saturation
        cyc(1'b1, 1'b0, 6'd0, 32'h0);
        for (int k = 0; k < 80; k++) cyc(1'b0, 1'b1, 6'd5, 32'hFFFF_FFFF);
        qry_page = 6'd5; #1;
        chk("R6 page rise clamp", qry_rise, (1 << PG_CW) - 1);
        chk("R6 page fall clamp", qry_fall, (1 << PG_CW) - 1);

        // R5: cumulative per-page counters survive window closes
        for (int p = 0; p < 64; p++) begin
            qry_page = 6'(p); #1;
            chk("R5 page rise", qry_rise, m_pr[p]);
            chk("R5 page fall", qry_fall, m_pf[p]);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule